// File: doc/BRIEF.md
# Byte-Lane Data Memory with Width-Selected Stores

This block is a word-wide data store addressed in bytes. Each cycle the caller presents an enable, a two-bit operation code, a byte address and a 32-bit write value. The operation code selects either a full-word read or a store of one, two or four bytes. A store changes only the byte lanes covered by its width and position, and leaves every other byte of the word as it was. A read returns the whole aligned word that holds the addressed byte.

Alignment is checked for every enabled request. A halfword request at an odd address, or a word request whose two low address bits are not zero, is refused. For that cycle the block raises an error output and changes nothing. Byte order is little-endian. The depth of the array is a parameter. Address bits above the word index are ignored, so addresses that differ only in those bits reach the same word.

Top module: `bmem_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, every byte of the array is cleared. After reset, every aligned read returns 0x00000000.
- R2: With `en`=1, `op`=2'b00 and `addr[1:0]`=2'b00, `rdata` combinationally returns the stored word, with byte offset 0 on bits 7:0 and byte offset 3 on bits 31:24.
- R3: With `en`=1 and `op`=2'b01, the rising edge writes `wdata[7:0]` into the lane selected by `addr[1:0]` at any address. The other three lanes keep their values, and `err` stays 0.
- R4: With `en`=1, `op`=2'b10 and `addr[0]`=0, the rising edge writes `wdata[15:0]`. It goes into lanes 1:0 when `addr[1]`=0 and into lanes 3:2 when `addr[1]`=1. The other two lanes are unchanged.
- R5: With `en`=1, `op`=2'b11 and `addr[1:0]`=2'b00, the rising edge writes all 32 bits of `wdata`. A read of the same word in the next cycle returns that value.
- R6: An enabled request is misaligned when it is a read or word store with `addr[1:0]`≠0, or a halfword store with `addr[0]`=1. For that cycle `err` is 1, no byte of the array changes and `rdata` is 0.
- R7: With `en`=0, no byte of the array changes, `err` is 0 and `rdata` is 0, whatever `op`, `addr` and `wdata` hold.
- R8: `rdata` is 0 in every cycle that is not an enabled, aligned read (`op`=2'b00), including enabled stores.
- R9: The word index is `addr[IDX_W+1:2]` with IDX_W = log2(`DEPTH`), which is 6 for the default of 64 words. Higher address bits have no effect: address 0x104 reaches the same word as 0x004.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores and reset act on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset that clears the array |
| en | input | 1 | Request enable; when low, nothing is read or written |
| op | input | 2 | 00 word read, 01 byte store, 10 halfword store, 11 word store |
| addr | input | ADDR_W (32) | Byte address |
| wdata | input | 32 | Store value, taken from its low bits for narrow stores |
| rdata | output | 32 | Aligned word for an enabled aligned read, 0 otherwise |
| err | output | 1 | Misaligned enabled request in this cycle |

## Verification
The read data and the error flag are combinational, so both are due in the same cycle as the request. The bench drives each request just after a falling edge and samples `rdata` and `err` one nanosecond later, before the rising edge. A store takes effect at the rising edge that ends its cycle, so its result is checked by a read issued after the next falling edge, one cycle later. Checks that a refused or disabled request changed nothing use the same read one cycle later, and compare the value with the one written before the request.

// File: rtl/bmem_pkg.sv
// Package: shared types and widths for the byte-lane data memory.
// Assumes a 32-bit data path built from four byte lanes.
package bmem_pkg;

    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    // Operation encoding on the op port
    typedef enum logic [1:0] {
        OP_READ = 2'b00,
        OP_BYTE = 2'b01,
        OP_HALF = 2'b10,
        OP_WORD = 2'b11
    } op_e;

endpackage

// File: rtl/bmem_align.sv
// Alignment check: flags a request whose byte offset does not suit its width.
// Byte stores are never misaligned; halfword needs offset bit 0 clear;
// word read and word store need both offset bits clear.
module bmem_align
    import bmem_pkg::*;
(
    input  logic [1:0]       op,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);

    // Decide alignment from operation width and low address bits
    always_comb begin
        unique case (op_e'(op))
            OP_BYTE: misaligned = 1'b0;
            OP_HALF: misaligned = off[0];
            OP_READ,
            OP_WORD: misaligned = (off != '0);
            default: misaligned = 1'b0;
        endcase
    end

endmodule

// File: rtl/bmem_lanes.sv
// Lane steering: turns a store request into per-lane write enables and
// lane-positioned write bytes. Assumes the request is already known to be
// aligned and enabled (store_ok); with store_ok low no lane is enabled.
module bmem_lanes
    import bmem_pkg::*;
(
    input  logic              store_ok,
    input  logic [1:0]        op,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  lane_we,
    output logic [DATA_W-1:0] lane_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(g);
        localparam int HALF_SLOT = g % 2;

        // Select the source byte and enable for this lane
        always_comb begin
            lane_we[g]                  = 1'b0;
            lane_data[g*LANE_W +: LANE_W] = wdata[g*LANE_W +: LANE_W];
            unique case (op_e'(op))
                OP_BYTE: begin
                    lane_we[g]                  = store_ok && (off == LANE_IDX);
                    lane_data[g*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
                end
                OP_HALF: begin
                    lane_we[g]                  = store_ok && (off[1] == LANE_IDX[1]);
                    lane_data[g*LANE_W +: LANE_W] = wdata[HALF_SLOT*LANE_W +: LANE_W];
                end
                OP_WORD: begin
                    lane_we[g] = store_ok;
                end
                default: begin
                    lane_we[g] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bmem_bank.sv
// Storage: one byte-wide bank per lane, DEPTH entries each. Writes happen on
// the rising edge per lane; the synchronous active-low reset clears all.
// Read is combinational from the indexed entry of every bank.
module bmem_bank
    import bmem_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] lane_data,
    output logic [DATA_W-1:0] word
);

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] cells [DEPTH];

        // Clear on reset, else update the indexed byte when enabled
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    cells[i] <= '0;
                end
            end else if (lane_we[g]) begin
                cells[idx] <= lane_data[g*LANE_W +: LANE_W];
            end
        end

        // Present this lane's byte of the indexed word
        assign word[g*LANE_W +: LANE_W] = cells[idx];
    end

endmodule

// File: rtl/bmem_top.sv
// Top: byte-addressed data memory with word read and byte/halfword/word
// stores. Assumes ADDR_W >= IDX_W + 2. Misaligned requests raise err and
// do nothing; with en low nothing is read or written.
module bmem_top
    import bmem_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);

    logic              misaligned;
    logic              store_ok;
    logic              read_ok;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] lane_data;
    logic [DATA_W-1:0] word;
    logic [IDX_W-1:0]  idx;

    // Word index from the bits above the byte offset
    assign idx = addr[IDX_W+OFF_W-1:OFF_W];

    if (ADDR_W > IDX_W + OFF_W) begin : g_hi
        logic unused_hi;
        // Upper address bits do not select storage
        assign unused_hi = ^addr[ADDR_W-1:IDX_W+OFF_W];
    end

    bmem_align u_align (
        .op         (op),
        .off        (addr[OFF_W-1:0]),
        .misaligned (misaligned)
    );

    // Qualify reads and stores by enable and alignment
    always_comb begin
        read_ok  = en && !misaligned && (op_e'(op) == OP_READ);
        store_ok = en && !misaligned && (op_e'(op) != OP_READ);
        err      = en && misaligned;
    end

    bmem_lanes u_lanes (
        .store_ok  (store_ok),
        .op        (op),
        .off       (addr[OFF_W-1:0]),
        .wdata     (wdata),
        .lane_we   (lane_we),
        .lane_data (lane_data)
    );

    bmem_bank #(.DEPTH(DEPTH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .lane_we   (lane_we),
        .lane_data (lane_data),
        .word      (word)
    );

    // Drive read data only for an enabled aligned read
    assign rdata = read_ok ? word : '0;

endmodule

// File: rtl/bmem_chk.sv
// Checker: temporal properties on the memory's ports and lane enables.
// Assumes the bound instance's clk and synchronous active-low reset.
module bmem_chk #(
    parameter int ADDR_W = 32
)(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [1:0]        op,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              err,
    input logic [3:0]        lane_we
);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!err && rdata == 32'h0 && lane_we == 4'h0));

    // R6
    refused_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (lane_we == 4'h0 && rdata == 32'h0));

    // R6
    bad_word_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op[0] == op[1] && addr[1:0] != 2'b00) |-> err);

    // R4
    bad_half_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 2'b10 && addr[0]) |-> err);

    // R3
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 2'b01) |-> (!err && $countones(lane_we) == 1));

    // R8
    store_no_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op != 2'b00) |-> rdata == 32'h0);

    // R5
    word_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 2'b11 && addr[1:0] == 2'b00) |=>
        (!(en && op == 2'b00 && addr == $past(addr)) || rdata == $past(wdata)));

endmodule

bind bmem_top bmem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .op      (op),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .err     (err),
    .lane_we (lane_we)
);

// File: tb/bmem_top_tb.sv
// Directed bench for bmem_top: one task per scenario, each checking itself.
module bmem_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bmem_top u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .op    (op),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .err   (err)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One request cycle: drive after falling edge, sample before rising edge
    task automatic cyc(input logic e, input logic [1:0] o, input logic [31:0] a,
                       input logic [31:0] d, output logic er, output logic [31:0] r);
        @(negedge clk);
        en = e; op = o; addr = a; wdata = d;
        #1;
        er = err;
        r = rdata;
        @(posedge clk);
    endtask

    task automatic store(input logic [1:0] o, input logic [31:0] a, input logic [31:0] d,
                         input string req, input logic exp_err);
        logic er;
        logic [31:0] r;
        cyc(1'b1, o, a, d, er, r);
        check(req, {31'b0, er}, {31'b0, exp_err});
    endtask

    task automatic expect_word(input logic [31:0] a, input logic [31:0] exp, input string req);
        logic er;
        logic [31:0] r;
        cyc(1'b1, 2'b00, a, 32'h0, er, r);
        check(req, r, exp);
    endtask

    task automatic t_reset();
        expect_word(32'h0000_0000, 32'h0, "R1");
        expect_word(32'h0000_003C, 32'h0, "R1");
        expect_word(32'h0000_00FC, 32'h0, "R1");
    endtask

    task automatic t_word();
        store(2'b11, 32'h10, 32'hDEAD_BEEF, "R5", 1'b0);
        expect_word(32'h10, 32'hDEAD_BEEF, "R5");
        store(2'b11, 32'h14, 32'h0123_4567, "R5", 1'b0);
        expect_word(32'h14, 32'h0123_4567, "R2");
        expect_word(32'h10, 32'hDEAD_BEEF, "R2");
    endtask

    task automatic t_byte();
        store(2'b11, 32'h20, 32'h1122_3344, "R5", 1'b0);
        store(2'b01, 32'h21, 32'hFFFF_FFAA, "R3", 1'b0);
        expect_word(32'h20, 32'h1122_AA44, "R3");
        store(2'b01, 32'h23, 32'h0000_0055, "R3", 1'b0);
        expect_word(32'h20, 32'h5522_AA44, "R3");
    endtask

    task automatic t_half();
        store(2'b11, 32'h30, 32'h0, "R5", 1'b0);
        store(2'b10, 32'h32, 32'hABCD_BEEF, "R4", 1'b0);
        expect_word(32'h30, 32'hBEEF_0000, "R4");
        store(2'b10, 32'h30, 32'h0000_1234, "R4", 1'b0);
        expect_word(32'h30, 32'hBEEF_1234, "R4");
    endtask

    task automatic t_misalign();
        logic er;
        logic [31:0] r;
        store(2'b11, 32'h40, 32'hCAFE_F00D, "R5", 1'b0);
        store(2'b11, 32'h41, 32'h0, "R6", 1'b1);
        expect_word(32'h40, 32'hCAFE_F00D, "R6");
        store(2'b10, 32'h43, 32'h0, "R6", 1'b1);
        expect_word(32'h40, 32'hCAFE_F00D, "R6");
        cyc(1'b1, 2'b00, 32'h42, 32'h0, er, r);
        check("R6", {31'b0, er}, 32'h1);
        check("R6", r, 32'h0);
        store(2'b01, 32'h41, 32'h0000_0077, "R3", 1'b0);
        expect_word(32'h40, 32'hCAFE_770D, "R3");
    endtask

    task automatic t_disable();
        logic er;
        logic [31:0] r;
        cyc(1'b0, 2'b11, 32'h40, 32'h0, er, r);
        check("R7", {31'b0, er}, 32'h0);
        check("R7", r, 32'h0);
        cyc(1'b0, 2'b11, 32'h41, 32'h0, er, r);
        check("R7", {31'b0, er}, 32'h0);
        cyc(1'b0, 2'b00, 32'h40, 32'h0, er, r);
        check("R7", r, 32'h0);
        expect_word(32'h40, 32'hCAFE_770D, "R7");
        cyc(1'b1, 2'b01, 32'h40, 32'h0000_000D, er, r);
        check("R8", r, 32'h0);
        expect_word(32'h40, 32'hCAFE_770D, "R8");
    endtask

    task automatic t_wrap();
        store(2'b11, 32'h104, 32'h0BAD_CAFE, "R9", 1'b0);
        expect_word(32'h004, 32'h0BAD_CAFE, "R9");
        expect_word(32'hFFFF_FF10, 32'hDEAD_BEEF, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word();
        t_byte();
        t_half();
        t_misalign();
        t_disable();
        t_wrap();
        @(negedge clk);
        en = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule